// File: doc/BRIEF.md
# Hardware Barrier Synchronization Unit

This block lets a group of processors meet at a common point before any of them continues. Each processor has one request line, `arrive`, and one grant line, `go_o`. The unit keeps a single shared tally of the processors now waiting. When the tally reaches a participant count that was set beforehand, every waiter gets its grant in the same cycle. The tally then returns to zero, ready for the next meeting.

An arrival is a request line that rises while its processor is idle. Requests that rise in the same cycle are all counted. The grant stays high until the processor lowers its request, and only after that can the processor join the next episode. A phase flag shows the state of the current episode: the first arrival clears it and the completing arrival sets it.

A processor that raises its request a second time while it is still waiting is not counted again. It sets a sticky error bit instead. The participant count is written through a one-cycle write strobe. A count of zero or above the processor total is refused, and the unit then ignores all arrivals.

Top module: `barrier_sync`

## Requirements
- R1: After synchronous reset, `go_o` is all zero, `arrived_o` is 0, `flag_o` is 0, `dbl_err_o` is 0 and `ready_o` is 0.
- R2: A strobe on `cfg_we` with `cfg_count` in 1..NPROC sets `ready_o` from the next cycle. A value of 0 or above NPROC clears `ready_o`. While `ready_o` is 0, request lines are not counted and no grant is given.
- R3: Each processor whose request is high while it is idle adds one to `arrived_o` at the next clock edge. Several such requests in the same cycle are added together.
- R4: When the updated tally reaches or exceeds the participant count, the following happens at that clock edge. Every waiting processor and every processor arriving in that cycle sees `go_o` high, and `arrived_o` becomes 0.
- R5: While the updated tally is below the participant count, no waiting processor receives a grant.
- R6: `flag_o` is cleared by an arrival that finds the tally at zero, unless that same arrival completes the episode. It is set by the completing arrival.
- R7: A grant stays high while its request stays high. It falls one cycle after the request is lowered.
- R8: A rising request from a processor that is already waiting leaves `arrived_o` unchanged and sets `dbl_err_o`. `dbl_err_o` stays set until reset.
- R9: A processor still holding its request after a grant is not counted in the next episode. It is counted only after it lowers the request and raises it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Participant-count write strobe |
| cfg_count | input | CW | Participant count to load |
| arrive | input | NPROC | Per-processor arrival request, level |
| go_o | output | NPROC | Per-processor release grant |
| arrived_o | output | CW | Processors counted in the open episode |
| flag_o | output | 1 | Episode phase flag |
| ready_o | output | 1 | A valid participant count is loaded |
| dbl_err_o | output | 1 | Sticky double-arrival error |

## Verification
The bench builds the unit with NPROC = 4, which gives a 3-bit count. With this setting, several processors can arrive in one cycle, and one burst of four arrivals can pass a target of 2. It also lets a held grant overlap with a fresh arrival in the next episode. Both rejected counts are written: 0 and 5, one above the processor total.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WAIT = 2'd1,
        PS_GO   = 2'd2
    } pstate_e;

    function automatic logic count_in_range(input int unsigned c, input int unsigned n);
        return (c != 0) && (c <= n);
    endfunction

endpackage

// File: rtl/barrier_cfg.sv
module barrier_cfg
    import barrier_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int CW    = $clog2(NPROC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] target,
    output logic          ready
);

    logic ok;
    assign ok = count_in_range(int'(count), NPROC);

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
            ready  <= 1'b0;
        end else if (we) begin
            ready <= ok;
            if (ok) target <= count;
        end
    end

    p_bad_count_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (we && !ok) |=> !ready);

endmodule

// File: rtl/barrier_port.sv
module barrier_port
    import barrier_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic arrive,
    input  logic rel,
    output logic join_o,
    output logic go,
    output logic dbl
);

    pstate_e st, st_nx;
    logic    arr_q;

    assign join_o = en && arrive && (st == PS_IDLE);
    assign go     = (st == PS_GO);
    assign dbl    = (st == PS_WAIT) && arrive && !arr_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            PS_IDLE: if (join_o) st_nx = rel ? PS_GO : PS_WAIT;
            PS_WAIT: if (rel)    st_nx = PS_GO;
            PS_GO:   if (!arrive) st_nx = PS_IDLE;
            default: st_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PS_IDLE;
            arr_q <= 1'b0;
        end else begin
            st    <= st_nx;
            arr_q <= arrive;
        end
    end

    p_waiter_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (st == PS_WAIT && !rel) |=> (st == PS_WAIT));

    p_grant_held_r7: assert property (@(posedge clk) disable iff (rst)
        (go && arrive) |=> go);

endmodule

// File: rtl/barrier_count.sv
module barrier_count #(
    parameter int NPROC = 4,
    parameter int CW    = $clog2(NPROC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPROC-1:0] joins,
    input  logic [CW-1:0]    target,
    output logic             rel,
    output logic [CW-1:0]    cnt,
    output logic             flag
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } tally_t;

    tally_t      cur, nxt;
    logic [CW:0] nsum;
    logic [CW:0] total;

    always_comb begin
        nsum = '0;
        for (int i = 0; i < NPROC; i++)
            nsum = nsum + {{CW{1'b0}}, joins[i]};
        total = {1'b0, cur.cnt} + nsum;
        rel   = (nsum != '0) && (total >= {1'b0, target});
        nxt   = cur;
        if (rel) begin
            nxt.cnt  = '0;
            nxt.flag = 1'b1;
        end else if (nsum != '0) begin
            nxt.cnt = total[CW-1:0];
            if (cur.cnt == '0) nxt.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign cnt  = cur.cnt;
    assign flag = cur.flag;

    p_release_zeroes_r4: assert property (@(posedge clk) disable iff (rst)
        rel |=> (cnt == '0) && flag);

    p_first_clears_r6: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && (joins != '0) && !rel) |=> !flag);

endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
    import barrier_pkg::*;
#(
    parameter int NPROC = 4,
    localparam int CW   = $clog2(NPROC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CW-1:0]    cfg_count,
    input  logic [NPROC-1:0] arrive,
    output logic [NPROC-1:0] go_o,
    output logic [CW-1:0]    arrived_o,
    output logic             flag_o,
    output logic             ready_o,
    output logic             dbl_err_o
);

    logic [CW-1:0]    target;
    logic [NPROC-1:0] joins;
    logic [NPROC-1:0] dbl;
    logic             rel;
    logic             err_q;

    barrier_cfg #(.NPROC(NPROC), .CW(CW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .count(cfg_count),
        .target(target), .ready(ready_o)
    );

    barrier_count #(.NPROC(NPROC), .CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .joins(joins), .target(target),
        .rel(rel), .cnt(arrived_o), .flag(flag_o)
    );

    for (genvar g = 0; g < NPROC; g++) begin : g_port
        barrier_port u_port (
            .clk(clk), .rst(rst), .en(ready_o), .arrive(arrive[g]),
            .rel(rel), .join_o(joins[g]), .go(go_o[g]), .dbl(dbl[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)       err_q <= 1'b0;
        else if (|dbl) err_q <= 1'b1;
    end

    assign dbl_err_o = err_q;

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        dbl_err_o |=> dbl_err_o);

    p_idle_no_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && go_o == '0) |=> (go_o == '0));

endmodule

// File: tb/barrier_sync_test.sv
module barrier_sync_test;

    localparam int NPROC = 4;
    localparam int CW    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [CW-1:0]    cfg_count = '0;
    logic [NPROC-1:0] arrive = '0;
    logic [NPROC-1:0] go_o;
    logic [CW-1:0]    arrived_o;
    logic             flag_o, ready_o, dbl_err_o;

    always #4 clk = ~clk;

    barrier_sync #(.NPROC(NPROC)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_count(cfg_count),
        .arrive(arrive), .go_o(go_o), .arrived_o(arrived_o),
        .flag_o(flag_o), .ready_o(ready_o), .dbl_err_o(dbl_err_o)
    );

    typedef struct {
        logic [NPROC-1:0] go;
        logic [CW-1:0]    cnt;
        logic             flag;
        logic             err;
        logic             rdy;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    task automatic step(input bit we, input int cv, input logic [NPROC-1:0] arr,
                        input logic [NPROC-1:0] eg, input int ec, input bit ef,
                        input bit ee, input bit er, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we    = we;
        cfg_count = CW'(cv);
        arrive    = arr;
        e.go = eg; e.cnt = CW'(ec); e.flag = ef; e.err = ee; e.rdy = er;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (go_o !== e.go || arrived_o !== e.cnt || flag_o !== e.flag ||
                    dbl_err_o !== e.err || ready_o !== e.rdy) begin
                    failures++;
                    $display("FAIL %s: go=%b cnt=%0d flag=%b err=%b rdy=%b expected go=%b cnt=%0d flag=%b err=%b rdy=%b",
                             t, go_o, arrived_o, flag_o, dbl_err_o, ready_o,
                             e.go, e.cnt, e.flag, e.err, e.rdy);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        exp_q.push_back('{go: '0, cnt: '0, flag: 1'b0, err: 1'b0, rdy: 1'b0});
        tag_q.push_back("R1 reset");
        // R2 rejected counts, arrivals ignored
        step(1, 0, 4'b0000, 4'b0000, 0, 0, 0, 0, "R2 count zero refused");
        step(0, 0, 4'b0001, 4'b0000, 0, 0, 0, 0, "R2 arrival ignored when not ready");
        step(1, 5, 4'b0000, 4'b0000, 0, 0, 0, 0, "R2 count above total refused");
        step(1, 3, 4'b0000, 4'b0000, 0, 0, 0, 1, "R2 valid count accepted");
        // Episode 1, target 3
        step(0, 0, 4'b0001, 4'b0000, 1, 0, 0, 1, "R3 R5 R6 first arrival");
        step(0, 0, 4'b0111, 4'b0111, 0, 1, 0, 1, "R3 R4 two arrivals complete");
        step(0, 0, 4'b0111, 4'b0111, 0, 1, 0, 1, "R7 grant held");
        step(0, 0, 4'b0110, 4'b0110, 0, 1, 0, 1, "R7 grant drops after request");
        step(0, 0, 4'b0000, 4'b0000, 0, 1, 0, 1, "R7 all released");
        // Episode 2, double arrival
        step(0, 0, 4'b0010, 4'b0000, 1, 0, 0, 1, "R6 first arrival clears flag");
        step(0, 0, 4'b0000, 4'b0000, 1, 0, 0, 1, "R5 waiter keeps waiting");
        step(0, 0, 4'b0010, 4'b0000, 1, 0, 1, 1, "R8 re-raise ignored, error set");
        step(0, 0, 4'b1010, 4'b0000, 2, 0, 1, 1, "R3 R8 count and sticky error");
        step(0, 0, 4'b1011, 4'b1011, 0, 1, 1, 1, "R4 release incl. early waiter");
        // Episode 3 overlapping held grants
        step(0, 0, 4'b1111, 4'b1011, 1, 0, 1, 1, "R9 held grants not counted");
        step(0, 0, 4'b0100, 4'b0000, 1, 0, 1, 1, "R9 R7 grants drop, waiter stays");
        step(0, 0, 4'b0101, 4'b0000, 2, 0, 1, 1, "R9 re-joined after drop");
        step(0, 0, 4'b0111, 4'b0111, 0, 1, 1, 1, "R4 third episode complete");
        step(0, 0, 4'b0000, 4'b0000, 0, 1, 1, 1, "R7 released");
        // Overshoot, target 2
        step(1, 2, 4'b0000, 4'b0000, 0, 1, 1, 1, "R2 reload count 2");
        step(0, 0, 4'b1111, 4'b1111, 0, 1, 1, 1, "R4 burst passes target");
        step(0, 0, 4'b0000, 4'b0000, 0, 1, 1, 1, "R7 burst released");
        // Refused count after valid one
        step(1, 0, 4'b0000, 4'b0000, 0, 1, 1, 0, "R2 count zero makes idle");
        step(0, 0, 4'b0001, 4'b0000, 0, 1, 1, 0, "R2 arrival ignored after refusal");
        step(0, 0, 4'b0000, 4'b0000, 0, 1, 1, 0, "R2 still idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule